// File: doc/BRIEF.md
# Watchdog Timer with NMI Escalation

This block is a watchdog that counts clock cycles while it is armed. When the count reaches a programmed limit, the watchdog fires. One 16-bit control word holds the arm bit, a mode bit, two sticky status flags and the limit. The whole word can be read at any time. Any write to it restarts the count, so software services the watchdog by rewriting the word.

A timeout does one of two things. It either sends a one-cycle pulse on the non-maskable interrupt output, or it asserts an internal reset request for a fixed number of cycles. The mode bit chooses between them, but escalation overrides it. If an earlier interrupt was flagged and software has not cleared that flag, the next timeout becomes a reset whatever the mode bit says. An internal reset returns the control word to its power-on value but keeps both status flags. Only the external reset clears the flags.

The external reset is active low and asserts asynchronously. Its release passes through a two-stage synchronizer. The logic resumes on the third rising edge after `rst_n` rises.

Top module: `wdt_nmi_escalate`

## Requirements
- R1: After external reset the control word reads 0xC080 and both `nmi_o` and `wdt_rst_o` are low. The layout is: bit 15 arm, bit 14 mode (1 = reset), bit 13 reset flag, bit 12 interrupt flag, bits 11:8 always read 0, bits 7:0 limit.
- R2: While bit 15 is 0 the counter is held at zero and no timeout occurs.
- R3: When armed, a timeout occurs on the cycle the counter equals the limit. This is limit+1 cycles after a restart. The counter then restarts from zero.
- R4: A write restarts the counter and suppresses a timeout in that cycle. Bits 15, 14 and 7:0 take the written value.
- R5: Writing 0 to bit 13 or bit 12 clears that flag. Writing 1 leaves it unchanged.
- R6: A timeout with bit 14 = 1 sets bit 13 and holds `wdt_rst_o` high for exactly 4 cycles, starting the next cycle.
- R7: A timeout with bit 14 = 0 and bit 12 = 0 sets bit 12 and gives a one-cycle `nmi_o` pulse in the next cycle, with no reset.
- R8: A timeout while bit 12 = 1 produces the reset of R6 regardless of bit 14.
- R9: An internal reset reloads bits 15, 14 and 7:0 to their reset values and keeps bits 13 and 12. Writes are ignored and the counter stays at zero while `wdt_rst_o` is high.
- R10: An external reset clears both flags.
- R11: `nmi_o` and `wdt_rst_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | External reset, active low, asynchronous assert |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Current control word |
| nmi_o | output | 1 | One-cycle non-maskable interrupt pulse |
| wdt_rst_o | output | 1 | Internal reset request |

## Verification
A wrong count or a wrong limit comparison moves the timeout by at least one cycle. The bench compares `nmi_o` and `wdt_rst_o` every cycle, so the first misplaced pulse shows the fault. A lost or stuck flag does not show at once. It appears on `rd_data` in the same cycle, but it only changes the outputs at the next timeout, where an interrupt turns into a reset or the other way round. A reload fault after an internal reset shows on `rd_data` as soon as the pulse begins.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WORD_W   = 16;
  localparam int ARM_BIT  = 15;
  localparam int MODE_BIT = 14;
  localparam int RFL_BIT  = 13;
  localparam int NFL_BIT  = 12;
  localparam int RSVD_TOP = 11;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_NMI  = 2'd1,
    ACT_RST  = 2'd2
  } wdt_act_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             restart_i,
  input  logic             busy_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             hit;
  logic             hold;

  assign hit  = (cnt_q == limit_i);
  assign hold = busy_i || restart_i || !arm_i;
  assign expire_o = !hold && hit;

  always_comb begin
    cnt_d = cnt_q;
    if (hold)     cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_i);

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int PW = $clog2(RST_CYC + 1);
  localparam logic [PW-1:0] LOAD = PW'(RST_CYC);

  logic [PW-1:0] left_q;
  logic [PW-1:0] left_d;

  always_comb begin
    left_d = left_q;
    if (start_i)            left_d = LOAD;
    else if (left_q != '0)  left_d = left_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign busy_o = (left_q != '0);

  int run_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_len <= 0;
    else if (busy_o) run_len <= run_len + 1;
    else             run_len <= 0;
  end

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_len == RST_CYC));

  p_no_retrigger_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !start_i);
endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
#(
  parameter int               CNT_W     = 8,
  parameter logic [CNT_W-1:0] RST_LIMIT = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  wdt_act_e          act_i,
  output logic              arm_o,
  output logic              mode_o,
  output logic              nfl_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic [WORD_W-1:0] rd_data_o
);
  logic             arm_q, arm_d;
  logic             mode_q, mode_d;
  logic             rfl_q, rfl_d;
  logic             nfl_q, nfl_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             wr_ok;
  logic             upd;
  logic             unused_wr;

  assign wr_ok     = wr_en_i && !busy_i;
  assign upd       = wr_ok || (act_i != ACT_NONE);
  assign unused_wr = ^wr_data_i;

  always_comb begin
    arm_d  = arm_q;
    mode_d = mode_q;
    rfl_d  = rfl_q;
    nfl_d  = nfl_q;
    lim_d  = lim_q;
    if (act_i == ACT_RST) begin
      arm_d  = 1'b1;
      mode_d = 1'b1;
      lim_d  = RST_LIMIT;
      rfl_d  = 1'b1;
    end else if (act_i == ACT_NMI) begin
      nfl_d  = 1'b1;
    end else if (wr_ok) begin
      arm_d  = wr_data_i[ARM_BIT];
      mode_d = wr_data_i[MODE_BIT];
      rfl_d  = rfl_q & wr_data_i[RFL_BIT];
      nfl_d  = nfl_q & wr_data_i[NFL_BIT];
      lim_d  = wr_data_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b1;
      mode_q <= 1'b1;
      rfl_q  <= 1'b0;
      nfl_q  <= 1'b0;
      lim_q  <= RST_LIMIT;
    end else if (upd) begin
      arm_q  <= arm_d;
      mode_q <= mode_d;
      rfl_q  <= rfl_d;
      nfl_q  <= nfl_d;
      lim_q  <= lim_d;
    end
  end

  always_comb begin
    rd_data_o               = '0;
    rd_data_o[ARM_BIT]      = arm_q;
    rd_data_o[MODE_BIT]     = mode_q;
    rd_data_o[RFL_BIT]      = rfl_q;
    rd_data_o[NFL_BIT]      = nfl_q;
    rd_data_o[CNT_W-1:0]    = lim_q;
  end

  assign arm_o   = arm_q;
  assign mode_o  = mode_q;
  assign nfl_o   = nfl_q;
  assign limit_o = lim_q;

  p_rfl_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rfl_q && !(wr_ok && !wr_data_i[RFL_BIT]) |=> rfl_q);

  p_nfl_set_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !nfl_q && (act_i != ACT_NMI) |=> !nfl_q);

  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i == ACT_RST) |=> arm_q && mode_q && (lim_q == RST_LIMIT) && rfl_q);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && (act_i == ACT_NONE) |=> $stable(rd_data_o));
endmodule

// File: rtl/wdt_nmi_escalate.sv
module wdt_nmi_escalate
  import wdt_pkg::*;
#(
  parameter int               CNT_W     = 8,
  parameter logic [CNT_W-1:0] RST_LIMIT = 8'h80,
  parameter int               RST_CYC   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data,
  output logic        nmi_o,
  output logic        wdt_rst_o
);
  logic             rst_sync_n;
  logic             arm;
  logic             mode;
  logic             nfl;
  logic [CNT_W-1:0] limit;
  logic             busy;
  logic             expire;
  wdt_act_e         act;
  logic             nmi_q, nmi_d;

  wdt_rst_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdt_ctrl_reg #(.CNT_W(CNT_W), .RST_LIMIT(RST_LIMIT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .busy_i    (busy),
    .act_i     (act),
    .arm_o     (arm),
    .mode_o    (mode),
    .nfl_o     (nfl),
    .limit_o   (limit),
    .rd_data_o (rd_data)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .arm_i     (arm),
    .limit_i   (limit),
    .restart_i (wr_en),
    .busy_i    (busy),
    .expire_o  (expire)
  );

  always_comb begin
    act = ACT_NONE;
    if (expire) act = (mode || nfl) ? ACT_RST : ACT_NMI;
  end

  wdt_rst_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (act == ACT_RST),
    .busy_o  (busy)
  );

  always_comb nmi_d = (act == ACT_NMI);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) nmi_q <= 1'b0;
    else             nmi_q <= nmi_d;
  end

  assign nmi_o     = nmi_q;
  assign wdt_rst_o = busy;

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(nmi_o && wdt_rst_o));

  p_nmi_single_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nmi_o |=> !nmi_o);

  p_nmi_flagged_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    nmi_o |-> rd_data[NFL_BIT]);

  p_escalate_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    expire && nfl |=> wdt_rst_o && !nmi_o);

  p_no_fire_disarmed_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !arm |-> !expire);
endmodule

// File: tb/wdt_nmi_escalate_tb.sv
module wdt_nmi_escalate_tb;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        nmi_o;
  logic        wdt_rst_o;

  int n_chk;
  int n_bad;
  bit started;
  string phase;

  // behavioural reference state
  bit m_arm, m_mode, m_rfl, m_nfl, m_nmi;
  int m_lim, m_cnt, m_pulse, m_hold;

  wdt_nmi_escalate u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .nmi_o     (nmi_o),
    .wdt_rst_o (wdt_rst_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] m_word();
    return {m_arm, m_mode, m_rfl, m_nfl, 4'b0, 8'(m_lim)};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_arm = 1; m_mode = 1; m_rfl = 0; m_nfl = 0; m_lim = 128;
      m_cnt = 0; m_pulse = 0; m_nmi = 0; m_hold = 2;
    end else if (m_hold > 0) begin
      m_hold--;
    end else begin
      m_nmi = 0;
      if (m_pulse > 0) begin
        m_pulse--;
        m_cnt = 0;
      end else if (wr_en) begin
        m_arm  = wr_data[15];
        m_mode = wr_data[14];
        m_rfl  = m_rfl & wr_data[13];
        m_nfl  = m_nfl & wr_data[12];
        m_lim  = wr_data[7:0];
        m_cnt  = 0;
      end else if (!m_arm) begin
        m_cnt = 0;
      end else if (m_cnt == m_lim) begin
        m_cnt = 0;
        if (m_mode || m_nfl) begin
          m_rfl = 1; m_arm = 1; m_mode = 1; m_lim = 128; m_pulse = 4;
        end else begin
          m_nfl = 1; m_nmi = 1;
        end
      end else begin
        m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (started && rst_n) begin
      chk({phase, " word"}, rd_data, m_word());
      chk({phase, " nmi"}, {15'b0, nmi_o}, {15'b0, m_nmi});
      chk({phase, " rst"}, {15'b0, wdt_rst_o}, {15'b0, (m_pulse != 0)});
      if (nmi_o && wdt_rst_o) begin
        n_chk++; n_bad++;
        $display("FAIL R11 actual=both expected=exclusive t=%0t", $time);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ext_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    idle(3);
    #1 rst_n = 1'b1;
    started = 1'b1;
    idle(3);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    n_chk = 0; n_bad = 0; started = 0;
    phase = "R1";
    ext_reset();
    chk("R1 reset word", rd_data, 16'hC080);
    chk("R1 reset outputs", {14'b0, nmi_o, wdt_rst_o}, 16'h0000);

    phase = "R3 R6 default timeout";
    idle(140);
    chk("R6 reset flag set", rd_data, 16'hE080);

    phase = "R7 R8 nmi then escalation";
    wr(16'h8003);
    chk("R5 R4 write clears rfl", rd_data, 16'h8003);
    idle(16);
    chk("R8 R9 after escalation", rd_data, 16'hF080);

    phase = "R5 flags";
    wr(16'hB005);
    chk("R5 write one no effect", rd_data, 16'hB005);
    wr(16'h8005);
    chk("R5 write zero clears", rd_data, 16'h8005);

    phase = "R2 disarmed";
    wr(16'h0002);
    idle(20);
    chk("R2 disarmed word", rd_data, 16'h0002);

    phase = "R4 restart";
    wr(16'h8006);
    idle(4);
    wr(16'h8006);
    idle(4);
    idle(24);

    phase = "R9 write during pulse";
    wr(16'h9000);
    wr(16'h0001);
    idle(8);
    chk("R9 write ignored in pulse", rd_data, 16'hF080);

    phase = "R8 limit zero";
    wr(16'h8000);
    idle(10);
    chk("R8 limit zero escalates", rd_data, 16'hF080);

    phase = "R10";
    ext_reset();
    chk("R10 flags cleared", rd_data, 16'hC080);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule